// File: doc/BRIEF.md
# Tag Injection and Probe Stage

This is a purely combinational stage for a dataflow-tracking fabric. Every bit of a W-bit signal carries its logic value and a vector of T tag flags. One tag position, chosen by a parameter, can be forced on, forced off, or left alone. The choice is made per bit by a set control and a clear control. All other tag positions, and the logic values, go through unchanged. Downstream logic connects only to the rewritten signal, so the stage acts as an in-place overwrite placed between a driver and all of its loads. It can also be used as a plain pass-through rewrite cell.

The stage has two probes. The first reports, per bit, whether the selected tag is present on the rewritten output. The second reports whether the tag was present on the incoming signal, before any rewrite. Neither probe depends on the logic values. With both probes, a checker can compare the tag seen after an overwrite with the tag as it was first produced. Per-bit controls let each bit be tagged from its own condition, for example a per-bit overflow flag.

Top module: `tag_inject_probe`

## Requirements
- R1: `y_val` equals `a_val` for every input combination.
- R2: Tags are packed per bit, with the tags of bit i in `[i*NTAG +: NTAG]`. Every tag position other than `TAG_SEL` is copied from `a_tags` to `y_tags` unchanged.
- R3: When `set_i[i]` is 1, tag `TAG_SEL` of bit i on `y_tags` is 1, whatever `clr_i[i]` is.
- R4: When `set_i[i]` is 0 and `clr_i[i]` is 1, tag `TAG_SEL` of bit i on `y_tags` is 0.
- R5: When `set_i[i]` and `clr_i[i]` are both 0, tag `TAG_SEL` of bit i on `y_tags` equals that tag on `a_tags`.
- R6: `probe_now[i]` equals tag `TAG_SEL` of bit i on `y_tags`. Changing `a_val` has no effect on it.
- R7: `probe_orig[i]` equals tag `TAG_SEL` of bit i on `a_tags`. It is unaffected by `set_i`, `clr_i` and `a_val`.
- R8: The controls of bit i affect only bit i. A set on one bit leaves the tags of every other bit as they were on the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_val | input | NBIT | Logic values of the incoming signal |
| a_tags | input | NBIT*NTAG | Tag flags of the incoming signal, NTAG per bit |
| set_i | input | NBIT | Per-bit force-on of the selected tag |
| clr_i | input | NBIT | Per-bit force-off of the selected tag (loses to set) |
| y_val | output | NBIT | Logic values of the rewritten signal |
| y_tags | output | NBIT*NTAG | Tag flags of the rewritten signal |
| probe_now | output | NBIT | Selected tag present after the rewrite |
| probe_orig | output | NBIT | Selected tag present before the rewrite |

## Verification
The stage contains no registers, so every output is due in the same cycle as the inputs that produce it. The bench drives each vector on a falling clock edge. It samples the outputs one time unit before the next falling edge, when all combinational paths have settled, and then applies the next vector. Expected values come from bench functions that apply the priority rule one bit at a time. The bench mixes random vectors with directed cases for both-controls-high, clear-only, hold, single-bit set and value-only changes.

// File: rtl/tag_pkg.sv
package tag_pkg;

  // Next state of the selected tag: set dominates clear, otherwise hold.
  function automatic logic tag_next(input logic cur, input logic set, input logic clr);
    logic r;
    r = cur;
    if (set)      r = 1'b1;
    else if (clr) r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/tag_column_extract.sv
module tag_column_extract #(
  parameter int NBIT    = 8,
  parameter int NTAG    = 4,
  parameter int TAG_SEL = 2
) (
  input  logic [NBIT*NTAG-1:0] tags,
  output logic [NBIT-1:0]      column
);

  for (genvar i = 0; i < NBIT; i++) begin : g_col
    assign column[i] = tags[i*NTAG + TAG_SEL];
  end

endmodule

// File: rtl/tag_bit_rewrite.sv
module tag_bit_rewrite
  import tag_pkg::*;
#(
  parameter int NTAG    = 4,
  parameter int TAG_SEL = 2
) (
  input  logic            val_in,
  input  logic [NTAG-1:0] tags_in,
  input  logic            set,
  input  logic            clr,
  output logic            val_out,
  output logic [NTAG-1:0] tags_out
);

  logic sel_next;

  assign sel_next = tag_next(tags_in[TAG_SEL], set, clr);
  assign val_out  = val_in;

  always_comb begin
    tags_out          = tags_in;
    tags_out[TAG_SEL] = sel_next;
  end

  // Guard the priority rule on the cell boundary.
  always_comb begin
    if (set)
      assert_set_wins_R3: assert (tags_out[TAG_SEL] == 1'b1);
    if (!set && clr)
      assert_clr_only_R4: assert (tags_out[TAG_SEL] == 1'b0);
    if (!set && !clr)
      assert_hold_R5: assert (tags_out[TAG_SEL] == tags_in[TAG_SEL]);
  end

endmodule

// File: rtl/tag_inject_probe.sv
module tag_inject_probe #(
  parameter int NBIT    = 8,
  parameter int NTAG    = 4,
  parameter int TAG_SEL = 2
) (
  input  logic [NBIT-1:0]      a_val,
  input  logic [NBIT*NTAG-1:0] a_tags,
  input  logic [NBIT-1:0]      set_i,
  input  logic [NBIT-1:0]      clr_i,
  output logic [NBIT-1:0]      y_val,
  output logic [NBIT*NTAG-1:0] y_tags,
  output logic [NBIT-1:0]      probe_now,
  output logic [NBIT-1:0]      probe_orig
);

  localparam int TOTAL = NBIT * NTAG;

  if (TAG_SEL < 0 || TAG_SEL >= NTAG) begin : g_bad_sel
    $error("tag_inject_probe: TAG_SEL out of range of NTAG");
  end

  // Rewritten signal, seen by every load (in-place overwrite).
  logic [TOTAL-1:0] rewritten_tags;
  logic [NBIT-1:0]  rewritten_val;

  for (genvar i = 0; i < NBIT; i++) begin : g_bit
    tag_bit_rewrite #(
      .NTAG   (NTAG),
      .TAG_SEL(TAG_SEL)
    ) u_rw (
      .val_in  (a_val[i]),
      .tags_in (a_tags[i*NTAG +: NTAG]),
      .set     (set_i[i]),
      .clr     (clr_i[i]),
      .val_out (rewritten_val[i]),
      .tags_out(rewritten_tags[i*NTAG +: NTAG])
    );
  end

  // Probe after the rewrite.
  tag_column_extract #(
    .NBIT(NBIT), .NTAG(NTAG), .TAG_SEL(TAG_SEL)
  ) u_probe_now (
    .tags  (rewritten_tags),
    .column(probe_now)
  );

  // Probe ahead of the rewrite.
  tag_column_extract #(
    .NBIT(NBIT), .NTAG(NTAG), .TAG_SEL(TAG_SEL)
  ) u_probe_orig (
    .tags  (a_tags),
    .column(probe_orig)
  );

  assign y_val  = rewritten_val;
  assign y_tags = rewritten_tags;

  // Cross-module checks on the stage outputs.
  always_comb begin
    assert_value_pass_R1: assert (y_val == a_val);
    for (int i = 0; i < NBIT; i++) begin
      for (int t = 0; t < NTAG; t++) begin
        if (t != TAG_SEL)
          assert_other_tags_R2: assert (y_tags[i*NTAG + t] == a_tags[i*NTAG + t]);
      end
      assert_probe_now_R6: assert (probe_now[i] == y_tags[i*NTAG + TAG_SEL]);
      assert_probe_orig_R7: assert (probe_orig[i] == a_tags[i*NTAG + TAG_SEL]);
      if (!set_i[i] && !clr_i[i])
        assert_bits_agree_R8: assert (probe_now[i] == probe_orig[i]);
    end
  end

endmodule

// File: tb/tag_inject_probe_tb_top.sv
module tag_inject_probe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NBIT    = 8;
  localparam int NTAG    = 4;
  localparam int TAG_SEL = 2;
  localparam int TOTAL   = NBIT * NTAG;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NBIT-1:0]  a_val, set_i, clr_i;
  logic [TOTAL-1:0] a_tags;
  logic [NBIT-1:0]  y_val, probe_now, probe_orig;
  logic [TOTAL-1:0] y_tags;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  tag_inject_probe #(.NBIT(NBIT), .NTAG(NTAG), .TAG_SEL(TAG_SEL)) dut_i (
    .a_val(a_val), .a_tags(a_tags), .set_i(set_i), .clr_i(clr_i),
    .y_val(y_val), .y_tags(y_tags), .probe_now(probe_now), .probe_orig(probe_orig)
  );

  // Bench model: walk bit by bit, written as a case on the control pair.
  function automatic logic [TOTAL-1:0] exp_tags(input logic [TOTAL-1:0] t,
                                                 input logic [NBIT-1:0] s,
                                                 input logic [NBIT-1:0] c);
    logic [TOTAL-1:0] r = t;
    for (int i = 0; i < NBIT; i++) begin
      case ({s[i], c[i]})
        2'b10, 2'b11: r[i*NTAG + TAG_SEL] = 1'b1;
        2'b01:        r[i*NTAG + TAG_SEL] = 1'b0;
        default:      ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [NBIT-1:0] column(input logic [TOTAL-1:0] t);
    logic [NBIT-1:0] r;
    for (int i = 0; i < NBIT; i++) r[i] = t[i*NTAG + TAG_SEL];
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [NBIT-1:0] v, input logic [TOTAL-1:0] t,
                       input logic [NBIT-1:0] s, input logic [NBIT-1:0] c);
    @(negedge clk);
    a_val = v; a_tags = t; set_i = s; clr_i = c;
    #(CLK_PERIOD - 1);
  endtask

  task automatic check_all(input string tag);
    logic [TOTAL-1:0] et;
    et = exp_tags(a_tags, set_i, clr_i);
    check("R1", {tag, " y_val"}, 64'(y_val), 64'(a_val));
    check("R2", {tag, " y_tags"}, 64'(y_tags), 64'(et));
    check("R6", {tag, " probe_now"}, 64'(probe_now), 64'(column(et)));
    check("R7", {tag, " probe_orig"}, 64'(probe_orig), 64'(column(a_tags)));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [NBIT-1:0] pn_keep;
    process::self().srandom(32'h5eed_0044);
    // Idle state: everything zero.
    apply('0, '0, '0, '0);
    check("R1", "idle y_val", 64'(y_val), 64'h0);
    check("R2", "idle y_tags", 64'(y_tags), 64'h0);
    check("R6", "idle probe_now", 64'(probe_now), 64'h0);

    // R3: set and clear both high, tags clear on input.
    apply(8'hA5, '0, '1, '1);
    check("R3", "set over clr", 64'(probe_now), 64'hFF);
    check("R7", "orig unaffected by set", 64'(probe_orig), 64'h0);

    // R4: clear only, tags all high on input.
    apply(8'h3C, '1, '0, '1);
    check("R4", "clr only", 64'(probe_now), 64'h0);
    check("R2", "others kept on clr", 64'(y_tags), 64'(exp_tags('1, '0, '1)));
    check("R7", "orig unaffected by clr", 64'(probe_orig), 64'hFF);

    // R5: hold, alternating tag pattern.
    apply(8'h0F, {TOTAL/4{4'b0100}} ^ {TOTAL/8{8'h40}}, '0, '0);
    check("R5", "hold", 64'(probe_now), 64'(column(a_tags)));

    // R8: set bit 0 only; other bits keep input tags.
    apply(8'h00, '0, 8'h01, '0);
    check("R8", "single bit set", 64'(y_tags), 64'(32'h1 << TAG_SEL));
    check("R8", "single bit probe", 64'(probe_now), 64'h01);

    // R6: value change alone does not move the probes.
    apply(8'h00, 32'h1234_5678, 8'h11, 8'h22);
    pn_keep = probe_now;
    apply(8'hFF, 32'h1234_5678, 8'h11, 8'h22);
    check("R6", "probe_now ignores value", 64'(probe_now), 64'(pn_keep));
    check("R1", "value follows", 64'(y_val), 64'hFF);

    // Random mix.
    for (int k = 0; k < 400; k++) begin
      apply(NBIT'($urandom), TOTAL'($urandom), NBIT'($urandom), NBIT'($urandom));
      check_all("rand");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule